// File: doc/BRIEF.md
# Soft-Start Reference Staircase Sequencer

This block generates the digital level for a switching regulator's internal reference while the regulator starts up. The level climbs as a monotonic staircase from zero to full scale. Time is counted in switching cycles, not in clock ticks: a one-clock strobe marks the start of each switching cycle, so the length of the ramp scales with the switching frequency. With the default parameters the level is 6 bits wide, and it advances one step after every 32 strobes. It reaches full scale (code 63) after 63 × 32 = 2016 strobes. Over its 64 levels the staircase spans the full 32 × 64 = 2048-cycle soft-start window, and the last level is then held.

When full scale is reached, `ss_active` falls and `ss_done` rises. A restart request (for example from an over-current monitor) forces the level to zero. The level then stays at zero for one whole soft-start duration of 2048 strobes before a fresh ramp begins. A second request during that wait starts the wait over. Dropping `enable` returns the block to zero at once. When `enable` comes back, a ramp starts immediately, with no wait.

All the ports are plain control and status pins. Nothing is transferred as a stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `softstart_stair_seq`

## Requirements
- R1: While `rst_n` is low, or while `enable` is low, `ref_code` is 0 and `ss_active` and `ss_done` are both 0; `cycle_start` and `restart_req` have no effect in that time.
- R2: During a ramp, `ref_code` rises by exactly one on the clock edge that captures every 32nd `cycle_start` pulse, counted from the start of the ramp. A clock edge without a `cycle_start` pulse never changes `ref_code`.
- R3: Outside a restart, disable or reset, `ref_code` never decreases, and it rises by at most one per clock edge.
- R4: One clock edge after `enable` is seen high (including the first edge after reset with `enable` already high), a ramp begins with `ref_code` = 0 and `ss_active` = 1, with no hold-at-zero interval.
- R5: `ref_code` reaches full scale (63) on the edge that captures the 2016th ramp pulse. On that same edge `ss_active` goes to 0 and `ss_done` goes to 1. Both are then held, and further pulses change nothing.
- R6: A `restart_req` seen high on a clock edge while `enable` is high sets `ref_code` to 0 and both flags to 0 on that edge, from any state.
- R7: After a restart, `ref_code` stays 0 with both flags low through 2047 `cycle_start` pulses. The edge that captures the 2048th pulse starts a new ramp (`ss_active` = 1, `ref_code` = 0).
- R8: A `restart_req` during the hold-at-zero interval restarts the 2048-pulse count from zero.
- R9: `ss_active` and `ss_done` are never high together, and `ss_done` is high only while `ref_code` is 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High to run; low clears the sequencer |
| cycle_start | input | 1 | One-clock strobe at the start of each switching cycle |
| restart_req | input | 1 | Request to drop to zero and wait one soft-start duration |
| ref_code | output | 6 | Reference level code, 0 to 63 |
| ss_active | output | 1 | High while the staircase is climbing |
| ss_done | output | 1 | High while full scale is held |

## Verification
The assertions check on every cycle that disable and restart clear the outputs, that `ref_code` moves only on a strobe and never falls or jumps by more than one, and that the two flags are exclusive, with `ss_done` tied to full scale. Some behaviour spans too many cycles for a property, and only the directed scenarios can show it. These are the exact 32-strobe cadence of each step, the arrival at full scale after 2016 strobes, the 2048-strobe length of the hold at zero, and the restart of that hold count by a second request. Likewise, only the bench shows that a ramp begins at once after `enable` returns, with no hold.

// File: rtl/ssseq_pkg.sv
package ssseq_pkg;

  typedef enum logic [1:0] {
    SS_OFF  = 2'd0,
    SS_RAMP = 2'd1,
    SS_HOLD = 2'd2,
    SS_FULL = 2'd3
  } ss_state_e;

endpackage

// File: rtl/ssseq_strobe_div.sv
// Counts strobes while enabled; flags the strobe that completes LIMIT.
module ssseq_strobe_div #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic strobe,
  output logic wrap
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap = run && strobe && !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && strobe) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssseq_level.sv
// Reference level register: clears, climbs one step, saturates at top.
module ssseq_level #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [CODE_W-1:0] code,
  output logic              at_last
);
  localparam logic [CODE_W-1:0] TOP     = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] PRE_TOP = TOP - 1'b1;

  logic [CODE_W-1:0] code_q;

  assign code    = code_q;
  assign at_last = (code_q == PRE_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clr) begin
      code_q <= '0;
    end else if (inc && (code_q != TOP)) begin
      code_q <= code_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssseq_ctrl.sv
// Phase control: off, climbing, waiting at zero, holding full scale.
module ssseq_ctrl
  import ssseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      restart_req,
  input  logic      step_tick,
  input  logic      level_at_last,
  input  logic      hold_wrap,
  output ss_state_e state,
  output logic      step_clr,
  output logic      step_run,
  output logic      hold_clr,
  output logic      hold_run,
  output logic      level_clr
);
  ss_state_e state_q, state_d;

  logic kill;
  assign kill = !enable || restart_req;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = SS_OFF;
    end else if (restart_req) begin
      state_d = SS_HOLD;
    end else begin
      unique case (state_q)
        SS_OFF:  state_d = SS_RAMP;
        SS_RAMP: if (step_tick && level_at_last) state_d = SS_FULL;
        SS_HOLD: if (hold_wrap) state_d = SS_RAMP;
        SS_FULL: state_d = SS_FULL;
        default: state_d = SS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SS_OFF;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign step_run  = (state_q == SS_RAMP);
  assign step_clr  = kill || (state_q != SS_RAMP);
  assign hold_run  = (state_q == SS_HOLD);
  assign hold_clr  = kill || (state_q != SS_HOLD);
  assign level_clr = kill;
endmodule

// File: rtl/softstart_stair_seq.sv
module softstart_stair_seq
  import ssseq_pkg::*;
#(
  parameter int CODE_W        = 6,
  parameter int CYC_PER_STEP  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cycle_start,
  input  logic              restart_req,
  output logic [CODE_W-1:0] ref_code,
  output logic              ss_active,
  output logic              ss_done
);
  localparam int NUM_STEPS = 2 ** CODE_W;
  localparam int HOLD_CYC  = CYC_PER_STEP * NUM_STEPS;

  ss_state_e state;
  logic step_clr, step_run, step_tick;
  logic hold_clr, hold_run, hold_wrap;
  logic level_clr, level_at_last;

  ssseq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .restart_req   (restart_req),
    .step_tick     (step_tick),
    .level_at_last (level_at_last),
    .hold_wrap     (hold_wrap),
    .state         (state),
    .step_clr      (step_clr),
    .step_run      (step_run),
    .hold_clr      (hold_clr),
    .hold_run      (hold_run),
    .level_clr     (level_clr)
  );

  ssseq_strobe_div #(.LIMIT(CYC_PER_STEP)) u_step_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (step_clr),
    .run    (step_run),
    .strobe (cycle_start),
    .wrap   (step_tick)
  );

  ssseq_strobe_div #(.LIMIT(HOLD_CYC)) u_hold_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (hold_clr),
    .run    (hold_run),
    .strobe (cycle_start),
    .wrap   (hold_wrap)
  );

  ssseq_level #(.CODE_W(CODE_W)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (level_clr),
    .inc     (step_tick),
    .code    (ref_code),
    .at_last (level_at_last)
  );

  assign ss_active = (state == SS_RAMP);
  assign ss_done   = (state == SS_FULL);
endmodule

// File: rtl/ssseq_checker.sv
module ssseq_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              cycle_start,
  input logic              restart_req,
  input logic [CODE_W-1:0] ref_code,
  input logic              ss_active,
  input logic              ss_done
);
  localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ref_code == '0) && !ss_active && !ss_done); // R1

  AST_NO_MOVE_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !restart_req && !cycle_start) |=> $stable(ref_code)); // R2

  AST_MONOTONIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !restart_req) |=>
      (ref_code == $past(ref_code)) || (ref_code == $past(ref_code) + 1'b1)); // R3

  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (ref_code == FULL_CODE)); // R5

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && restart_req) |=> (ref_code == '0) && !ss_active && !ss_done); // R6

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_active && ss_done)); // R9
endmodule

bind softstart_stair_seq ssseq_checker #(.CODE_W(CODE_W)) u_ssseq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .cycle_start (cycle_start),
  .restart_req (restart_req),
  .ref_code    (ref_code),
  .ss_active   (ss_active),
  .ss_done     (ss_done)
);

// File: tb/sim_softstart_stair_seq.sv
`timescale 1ns/1ps
module sim_softstart_stair_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic cycle_start = 1'b0;
  logic restart_req = 1'b0;
  logic [5:0] ref_code;
  logic ss_active, ss_done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  softstart_stair_seq u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cycle_start (cycle_start),
    .restart_req (restart_req),
    .ref_code    (ref_code),
    .ss_active   (ss_active),
    .ss_done     (ss_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input int c, input int a, input int d);
    check({req, " code"}, int'(ref_code), c);
    check({req, " active"}, int'(ss_active), a);
    check({req, " done"}, int'(ss_done), d);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cycle_start = 1'b1;
      @(negedge clk) cycle_start = 1'b0;
    end
  endtask

  task automatic pulse_restart();
    @(negedge clk) restart_req = 1'b1;
    @(negedge clk) restart_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1 reset", 0, 0, 0);
    cycle_start = 1'b1;
    @(negedge clk) cycle_start = 1'b0;
    check_out("R1 strobe in reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R4 ramp after reset", 0, 1, 0);
  endtask

  task automatic t_ramp_to_full();
    repeat (5) @(negedge clk);
    check_out("R2 idle clocks", 0, 1, 0);
    for (int i = 1; i <= 2016; i++) begin
      strobes(1);
      check("R2 R3 staircase code", int'(ref_code), i / 32);
      check("R5 active during ramp", int'(ss_active), (i < 2016) ? 1 : 0);
    end
    check_out("R5 full reached", 63, 0, 1);
    strobes(100);
    check_out("R5 full held", 63, 0, 1);
  endtask

  task automatic t_restart_hold();
    pulse_restart();
    check_out("R6 restart from full", 0, 0, 0);
    strobes(2047);
    check_out("R7 hold at zero", 0, 0, 0);
    strobes(1);
    check_out("R7 new ramp", 0, 1, 0);
    strobes(32);
    check_out("R7 first step", 1, 1, 0);
  endtask

  task automatic t_rehold();
    strobes(100);
    pulse_restart();
    check_out("R6 restart mid ramp", 0, 0, 0);
    strobes(1000);
    pulse_restart();
    strobes(2047);
    check_out("R8 hold count restarted", 0, 0, 0);
    strobes(1);
    check_out("R8 ramp after second hold", 0, 1, 0);
  endtask

  task automatic t_disable();
    strobes(20);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check_out("R1 disable clears", 0, 0, 0);
    strobes(50);
    pulse_restart();
    check_out("R1 ignored while off", 0, 0, 0);
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
    check_out("R4 ramp after enable", 0, 1, 0);
    strobes(31);
    check_out("R2 step counter cleared", 0, 1, 0);
    strobes(1);
    check_out("R2 step after 32", 1, 1, 0);
  endtask

  initial begin
    t_reset();
    t_ramp_to_full();
    t_restart_hold();
    t_rehold();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule